// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds a row of storage stages that can be filled all at once from a parallel word or moved one place at a time toward the last stage. The last stage drives a serial output together with its inverse. All logic runs on one fast system clock. The external inputs arrive without any timing relation to that clock, and each passes through a two-flop synchronizer.

Two strobe inputs are combined by a logical OR into one effective shift strobe. Either strobe can therefore serve as the shift clock while the other, held low, acts as an active-low enable. Each rising transition of the combined strobe, seen in the synchronized domain, shifts the register once. An active-low load input copies the parallel word into the stages for as long as it is low and overrides everything else.

Instances can be chained. The serial output of one instance drives the serial input of the next, and all instances share the strobes and the load input, which gives a longer parallel-to-serial converter.

Top module: `psr_shifter`

## Requirements
- R1: After `rst_n` is released, every stage reads 0, so `stages_o` = 0, `ser_out` = 0 and `ser_out_n` = 1.
- R2: While `load_n` is low, `stages_o` follows `par_in` (bit i of `par_in` goes to stage i), whatever `strobe_a`, `strobe_b` and `ser_in` do. An input change appears at the outputs no later than the third system clock edge after it.
- R3: When `load_n` returns high, the loaded value stays in place. No shift happens at the release, even if the combined strobe rose while load was held low.
- R4: With `load_n` high, a rising edge of (`strobe_a` OR `strobe_b`) performs one shift. Stage 0 takes `ser_in` and stage n takes stage n-1. `stages_o` bit i is stage i, and `ser_out` is stage WIDTH-1.
- R5: With `strobe_b` held low, low-to-high pulses on `strobe_a` shift the register once per pulse.
- R6: With `strobe_a` held low, low-to-high pulses on `strobe_b` shift the register once per pulse, because the two strobe roles are interchangeable.
- R7: While either strobe is held high, toggling the other strobe or `ser_in` leaves every stage unchanged.
- R8: If the enable strobe rises while the clock strobe is low, this counts as exactly one shift.
- R9: `ser_out_n` is always the complement of `ser_out`.
- R10: Two instances chained through `ser_out`→`ser_in`, with shared strobes and load, act as one 2·WIDTH-stage register. The downstream instance's stages sit above the upstream instance's stages.
- R11: A combined strobe that stays high for many system cycles produces exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strobe_a | input | 1 | Shift strobe input, OR-combined with strobe_b |
| strobe_b | input | 1 | Shift strobe input, OR-combined with strobe_a |
| load_n | input | 1 | Active-low parallel load, level sensitive |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel data, bit i into stage i |
| ser_out | output | 1 | Last stage value |
| ser_out_n | output | 1 | Complement of the last stage |
| stages_o | output | WIDTH | All stages, bit i is stage i (debug view) |

## Verification
The shift function is driven with strobe_a as clock and strobe_b as enable, and then with the roles swapped. Alternating and walking serial bit patterns show whether data enters stage 0 and moves exactly one place per edge, and whether the strobe roles really are interchangeable. Holding one strobe high while the other toggles separates correct gating from a register that reacts to any edge. An enable rising under a low clock, and a strobe that rises during load and is still high when load is released, tell exactly-one-shift behaviour apart from missed or spurious shifts. A two-instance chain loaded with distinct words is compared bit by bit against a 16-entry reference sequence, which confirms that the ordering survives across the instance boundary.

// File: rtl/psr_pkg.sv
package psr_pkg;
  // Operation applied to the stage array on a given system cycle
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } psr_op_e;
endpackage

// File: rtl/psr_sync.sv
// Multi-flop synchronizer for a bundle of asynchronous inputs.
module psr_sync #(
  parameter int unsigned       W       = 1,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0][W-1:0] pipe_q;
  logic [DEPTH-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {DEPTH{RST_VAL}};
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign sync_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/psr_strobe_edge.sv
// Combines the two synchronized strobes and turns a rising edge of the
// combination into a single-cycle shift request, suppressed during load.
module psr_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_a_s,
  input  logic strobe_b_s,
  input  logic load_n_s,
  output logic shift_o
);
  logic comb_now;
  logic prev_q;
  logic prev_d;

  always_comb begin
    comb_now = strobe_a_s | strobe_b_s;
    // History is refreshed every cycle, including while load is held,
    // so a level that rose under load is not seen as an edge afterwards.
    prev_d   = comb_now;
    shift_o  = comb_now & ~prev_q & load_n_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

  // One request per edge: a request is never followed by another at once
  assert_single_shift_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shift_o |=> !shift_o);

  // No request can leave this unit while load is active
  assert_no_shift_in_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_s |-> !shift_o);
endmodule

// File: rtl/psr_stage_array.sv
// The storage stages with per-stage next-state selection.
module psr_stage_array
  import psr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  psr_op_e          op_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] stage_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;
  logic             stage_en;

  assign stage_en = (op_i != OP_HOLD);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      logic shift_src;
      if (gi == 0) begin : g_first
        assign shift_src = ser_i;
      end else begin : g_rest
        assign shift_src = stage_q[gi-1];
      end
      assign stage_d[gi] = (op_i == OP_LOAD)  ? par_i[gi] :
                           (op_i == OP_SHIFT) ? shift_src  :
                                                stage_q[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  assign stage_o = stage_q;

  assert_load_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LOAD) |=> (stage_q == $past(par_i)));

  assert_shift_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SHIFT) |=> (stage_q == {$past(stage_q[LAST-1:0]), $past(ser_i)}));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_HOLD) |=> $stable(stage_q));
endmodule

// File: rtl/psr_shifter.sv
// Parallel-load serial-out shift register on a single system clock.
module psr_shifter
  import psr_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_a,
  input  logic             strobe_b,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n,
  output logic [WIDTH-1:0] stages_o
);
  localparam int unsigned DATA_W = WIDTH + 1;

  logic [1:0]        strobe_s;
  logic              load_n_s;
  logic [DATA_W-1:0] data_s;
  logic              shift_req;
  psr_op_e           op;
  logic [WIDTH-1:0]  stage_vec;

  // Strobes reset to the idle-high (hold) level so that no edge is seen
  // right after reset.
  psr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({strobe_b, strobe_a}),
    .sync_o  (strobe_s)
  );

  psr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (load_n),
    .sync_o  (load_n_s)
  );

  psr_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_in, par_in}),
    .sync_o  (data_s)
  );

  psr_strobe_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_a_s (strobe_s[0]),
    .strobe_b_s (strobe_s[1]),
    .load_n_s   (load_n_s),
    .shift_o    (shift_req)
  );

  always_comb begin
    if (!load_n_s) begin
      op = OP_LOAD;
    end else if (shift_req) begin
      op = OP_SHIFT;
    end else begin
      op = OP_HOLD;
    end
  end

  psr_stage_array #(.WIDTH(WIDTH)) u_stages (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op),
    .par_i   (data_s[WIDTH-1:0]),
    .ser_i   (data_s[WIDTH]),
    .stage_o (stage_vec)
  );

  assign ser_out   = stage_vec[WIDTH-1];
  assign ser_out_n = ~stage_vec[WIDTH-1];
  assign stages_o  = stage_vec;

  // A load decision and a shift decision never coincide
  assert_load_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_s |-> (op == OP_LOAD));
endmodule

// File: tb/sim_psr_shifter.sv
module sim_psr_shifter;
  localparam int W = 8;
  localparam int SETTLE = 4;

  logic clk;
  logic rst_n;
  logic strobe_a, strobe_b, load_n, ser_in;
  logic [W-1:0] par_in, par_in1;
  logic ser_out, ser_out_n, ser_out1, ser_out_n1;
  logic [W-1:0] stages_o, stages1;

  psr_shifter #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .load_n(load_n), .ser_in(ser_in), .par_in(par_in),
    .ser_out(ser_out), .ser_out_n(ser_out_n), .stages_o(stages_o)
  );

  psr_shifter #(.WIDTH(W)) u1 (
    .clk(clk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .load_n(load_n), .ser_in(ser_out), .par_in(par_in1),
    .ser_out(ser_out1), .ser_out_n(ser_out_n1), .stages_o(stages1)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    string      req;
    bit         chain;
    logic [W-1:0] exp_vec;
    logic       exp_bit;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;
  int    compared;
  int    mismatched;
  bit    done;

  logic [W-1:0]   model;
  logic [2*W-1:0] chain_model;

  // Monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        compared++;
        if (it.chain) begin
          if (ser_out1 !== it.exp_bit || ser_out_n1 !== ~it.exp_bit) begin
            mismatched++;
            $display("FAIL %s: chain out=%b/%b expected %b/%b", it.req,
                     ser_out1, ser_out_n1, it.exp_bit, ~it.exp_bit);
          end
        end else begin
          if (stages_o !== it.exp_vec || ser_out !== it.exp_vec[W-1] ||
              ser_out_n !== ~it.exp_vec[W-1]) begin
            mismatched++;
            $display("FAIL %s: stages=%h out=%b out_n=%b expected stages=%h out=%b out_n=%b",
                     it.req, stages_o, ser_out, ser_out_n,
                     it.exp_vec, it.exp_vec[W-1], ~it.exp_vec[W-1]);
          end
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_vec(input string req);
    item_t it;
    it.req = req; it.chain = 1'b0; it.exp_vec = model; it.exp_bit = model[W-1];
    sb_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic expect_chain(input string req);
    item_t it;
    it.req = req; it.chain = 1'b1; it.exp_vec = '0; it.exp_bit = chain_model[2*W-1];
    sb_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  // Shift with strobe_a as clock (use_b=0) or strobe_b as clock (use_b=1)
  task automatic shift_one(input bit use_b, input logic bit_in);
    if (use_b) strobe_b = 1'b0; else strobe_a = 1'b0;
    ser_in = bit_in;
    wait_cyc(SETTLE);
    if (use_b) strobe_b = 1'b1; else strobe_a = 1'b1;
    wait_cyc(SETTLE);
    model       = {model[W-2:0], bit_in};
    chain_model = {chain_model[2*W-2:0], bit_in};
  endtask

  task automatic do_load(input logic [W-1:0] v0, input logic [W-1:0] v1);
    par_in = v0; par_in1 = v1; load_n = 1'b0;
    wait_cyc(SETTLE);
    model = v0;
    chain_model = {v1, v0};
    load_n = 1'b1;
    wait_cyc(SETTLE);
  endtask

  initial begin
    int t;
    for (t = 0; t < 200000; t++) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    compared = 0; mismatched = 0; done = 1'b0;
    rst_n = 1'b0; strobe_a = 1'b1; strobe_b = 1'b0; load_n = 1'b1;
    ser_in = 1'b0; par_in = '0; par_in1 = '0;
    model = '0; chain_model = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(SETTLE);
    expect_vec("R1 reset state");

    // R2: load overrides strobes and serial input
    par_in = 8'hA5; load_n = 1'b0;
    wait_cyc(SETTLE);
    model = 8'hA5;
    expect_vec("R2 load value");
    strobe_a = 1'b0; ser_in = 1'b1; wait_cyc(SETTLE);
    strobe_a = 1'b1; wait_cyc(SETTLE);
    expect_vec("R2 strobe edge ignored under load");
    par_in = 8'h3C; wait_cyc(SETTLE);
    model = 8'h3C;
    expect_vec("R2 load follows par_in level");
    load_n = 1'b1; wait_cyc(SETTLE);
    expect_vec("R3 hold after release");

    // R5/R4: strobe_a as clock, strobe_b low as enable, alternating pattern
    strobe_b = 1'b0;
    for (int i = 0; i < W; i++) begin
      shift_one(1'b0, logic'(i % 2));
      expect_vec("R5 R4 shift via strobe_a");
    end

    // R6: roles swapped, walking one
    strobe_b = 1'b1; strobe_a = 1'b0; wait_cyc(SETTLE);
    do_load(8'h00, 8'h00);
    expect_vec("R2 reload zero");
    for (int i = 0; i < W; i++) begin
      shift_one(1'b1, (i == 0));
      expect_vec("R6 shift via strobe_b");
    end

    // R7: strobe_a held high, strobe_b and ser_in toggle
    strobe_a = 1'b1;
    for (int i = 0; i < 3; i++) begin
      strobe_b = 1'b0; ser_in = ~ser_in; wait_cyc(SETTLE);
      strobe_b = 1'b1; wait_cyc(SETTLE);
    end
    expect_vec("R7 hold with strobe_a high");
    strobe_b = 1'b1;
    for (int i = 0; i < 3; i++) begin
      strobe_a = 1'b0; wait_cyc(SETTLE);
      strobe_a = 1'b1; ser_in = ~ser_in; wait_cyc(SETTLE);
    end
    expect_vec("R7 hold with strobe_b high");

    // R8: enable rises while clock low -> exactly one shift
    do_load(8'hF0, 8'h00);
    strobe_a = 1'b0; wait_cyc(SETTLE);   // combined still high via strobe_b
    expect_vec("R8 no shift when clock falls under high enable");
    strobe_b = 1'b0; ser_in = 1'b1; wait_cyc(SETTLE);
    expect_vec("R8 no shift when enable falls");
    strobe_b = 1'b1; wait_cyc(SETTLE);
    model = {model[W-2:0], 1'b1};
    expect_vec("R8 enable rise under low clock gives one shift");

    // R11: combined strobe held high for a long time gives one shift
    strobe_b = 1'b0; ser_in = 1'b0; wait_cyc(SETTLE);
    strobe_b = 1'b1; wait_cyc(40);
    model = {model[W-2:0], 1'b0};
    expect_vec("R11 long high level shifts once");

    // R3: combined strobe rises during load, no shift at release
    strobe_a = 1'b0; strobe_b = 1'b0; wait_cyc(SETTLE);
    par_in = 8'h69; load_n = 1'b0; wait_cyc(SETTLE);
    strobe_a = 1'b1; wait_cyc(SETTLE);
    load_n = 1'b1; wait_cyc(SETTLE * 2);
    model = 8'h69;
    expect_vec("R3 no spurious shift at load release");

    // R10: two-instance chain against reference sequence
    strobe_b = 1'b0; strobe_a = 1'b1;
    do_load(8'hC3, 8'h5A);
    expect_chain("R10 chain initial out");
    for (int i = 0; i < 2 * W; i++) begin
      shift_one(1'b0, 1'b0);
      expect_chain("R10 chain shifted out");
    end
    expect_vec("R9 R10 upstream after chain");

    wait_cyc(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule